// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the two privileged return instructions of a hart with an optional hypervisor extension: the machine-level return and the supervisor-level return. When the strobe is high, the unit samples the following inputs:

- the current privilege and virtualization flag;
- the status fields (interrupt enables, previous-enable and previous-privilege fields, the trap-return control bits);
- the two saved exception PCs;
- the extension-present flags;
- the number of configured memory-protection rules.

The unit first decides whether the return is legal. If it is, one clock edge later the unit presents the new state: the return PC, the rewritten status fields, the new privilege and the new virtualization flag. A single-cycle pulse requests a swap of the hypervisor register bank when the return leaves a virtual context. If the return is not legal, the unit pulses an exception flag with a cause code and leaves every state output unchanged.

The surrounding core owns the status register storage. It feeds the current field values in and writes the unit's outputs back. The unit does not steer the pipeline and does not swap register banks; it only signals that a swap is needed.

Top module: `trap_return_unit`

## Requirements
- R1: Privilege encoding is user=0, supervisor=1, machine=3. A supervisor return issued at user privilege raises cause 2 (illegal instruction). A machine return issued below machine privilege also raises cause 2.
- R2: If the compressed-instruction flag is 0 and bits [1:0] of the selected return PC are not 00, the return raises cause 0 (misaligned). With the flag set, any PC is accepted and is presented on `pc_out`.
- R3: A supervisor return with the trap-supervisor-return bit set, issued below machine privilege, raises cause 2. At machine privilege the bit has no effect.
- R4: A supervisor return with the hypervisor flag set, virtualization on and the virtual-trap bit set raises cause 22 (virtual instruction).
- R5: Checks apply in this priority:
  - for a supervisor return: privilege, then alignment, then trap bit, then virtual trap bit;
  - for a machine return: privilege, then alignment, then the protection-rule check.

  The first check that fails sets the cause. An exception never coincides with `done`, and it leaves every state output and `swap_req` unchanged.
- R6: A supervisor return with the hypervisor flag set and virtualization off makes these changes:
  - new privilege becomes the old SPP;
  - new virtualization becomes the old SPV;
  - SPV and SPP are cleared;
  - SIE takes the old SPIE;
  - SPIE becomes 1;
  - `swap_req` pulses exactly when the old SPV was 1.
- R7: Any other supervisor return sets the new privilege from SPP, copies SPIE into SIE, sets SPIE to 1 and clears SPP. It leaves SPV and the virtualization flag unchanged and raises no swap.
- R8: A machine return copies MPIE into MIE, sets MPIE to 1, clears MPP and MPV, and sets the new privilege to the old MPP. Supervisor-side fields are unchanged.
- R9: A machine return with the hypervisor flag set makes the old MPV the new virtualization flag, and `swap_req` pulses when the old MPV was 1. Without the flag, virtualization is unchanged and no swap is requested.
- R10: If protection is implemented and zero rules are configured, a machine return whose old MPP is not machine raises cause 2. A nonzero rule count, or an MPP of machine, allows the return.
- R11: Results and pulses appear on the clock edge that samples the strobe and last one cycle. After reset, `priv_out` is 3, every other output is 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Return instruction strobe |
| ret_is_m | input | 1 | 1 = machine return, 0 = supervisor return |
| priv_in | input | 2 | Current privilege |
| virt_in | input | 1 | Current virtualization flag |
| has_c | input | 1 | Compressed instructions present |
| has_h | input | 1 | Hypervisor extension present |
| has_pmp | input | 1 | Memory protection implemented |
| pmp_rules | input | RULE_W | Number of configured protection rules |
| sepc | input | XLEN | Saved supervisor exception PC |
| mepc | input | XLEN | Saved machine exception PC |
| sie_in | input | 1 | Supervisor interrupt enable |
| spie_in | input | 1 | Supervisor previous interrupt enable |
| spp_in | input | 1 | Supervisor previous privilege |
| mie_in | input | 1 | Machine interrupt enable |
| mpie_in | input | 1 | Machine previous interrupt enable |
| mpp_in | input | 2 | Machine previous privilege |
| mpv_in | input | 1 | Machine previous virtualization |
| spv_in | input | 1 | Supervisor previous virtualization |
| tsr_in | input | 1 | Trap supervisor return bit |
| vtsr_in | input | 1 | Virtual trap supervisor return bit |
| done | output | 1 | Return committed (pulse) |
| exc_valid | output | 1 | Exception raised (pulse) |
| exc_cause | output | 5 | Exception cause code |
| pc_out | output | XLEN | Return PC |
| priv_out | output | 2 | New privilege |
| virt_out | output | 1 | New virtualization flag |
| sie_out | output | 1 | New SIE |
| spie_out | output | 1 | New SPIE |
| spp_out | output | 1 | New SPP |
| mie_out | output | 1 | New MIE |
| mpie_out | output | 1 | New MPIE |
| mpp_out | output | 2 | New MPP |
| mpv_out | output | 1 | New MPV |
| spv_out | output | 1 | New SPV |
| swap_req | output | 1 | Register-bank swap request (pulse) |

## Verification
Every result is registered once, so a bad decision shows at the ports one cycle after the strobe that caused it. A wrong check order shows as the wrong cause code. A missed check shows as `done` where an exception was due. A wrong field rewrite shows as a mismatched status, privilege or virtualization output. Because failed returns must hold the outputs, a state update that leaks through an exception shows as an output that changed on an `exc_valid` cycle. A leaked pulse shows on the idle cycle that follows each return.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [4:0] {
        EXC_MISALIGN = 5'd0,
        EXC_ILLEGAL  = 5'd2,
        EXC_VIRTUAL  = 5'd22
    } cause_e;

    typedef struct packed {
        logic       sie;
        logic       spie;
        logic       spp;
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       mpv;
        logic       spv;
    } stat_t;

    function automatic logic pc_unaligned(input logic c_ok, input logic [1:0] low);
        return !c_ok && (low != 2'b00);
    endfunction

endpackage

// File: rtl/trap_ret_check.sv
module trap_ret_check
    import trap_ret_pkg::*;
#(
    parameter int RULE_W = 4
) (
    input  logic              is_m,
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic              tsr,
    input  logic              vtsr,
    input  logic [1:0]        mpp,
    input  logic              has_c,
    input  logic              has_h,
    input  logic              has_pmp,
    input  logic [RULE_W-1:0] rules,
    input  logic [1:0]        pc_low,
    output logic              fault,
    output cause_e            cause
);
    logic unaligned;
    logic no_rules;

    assign unaligned = pc_unaligned(has_c, pc_low);
    assign no_rules  = (rules == '0);

    always_comb begin
        fault = 1'b0;
        cause = EXC_ILLEGAL;
        if (!is_m) begin
            if (priv < PRIV_S) begin
                fault = 1'b1;
            end else if (unaligned) begin
                fault = 1'b1;
                cause = EXC_MISALIGN;
            end else if (tsr && (priv < PRIV_M)) begin
                fault = 1'b1;
            end else if (has_h && virt && vtsr) begin
                fault = 1'b1;
                cause = EXC_VIRTUAL;
            end
        end else begin
            if (priv < PRIV_M) begin
                fault = 1'b1;
            end else if (unaligned) begin
                fault = 1'b1;
                cause = EXC_MISALIGN;
            end else if (has_pmp && no_rules && (mpp != PRIV_M)) begin
                fault = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trap_ret_sret.sv
module trap_ret_sret
    import trap_ret_pkg::*;
(
    input  stat_t       st,
    input  logic        virt,
    input  logic        has_h,
    output stat_t       nst,
    output logic [1:0]  npriv,
    output logic        nvirt,
    output logic        swap
);
    logic host_path;

    assign host_path = has_h && !virt;

    always_comb begin
        nst      = st;
        nst.sie  = st.spie;
        nst.spie = 1'b1;
        nst.spp  = 1'b0;
        npriv    = {1'b0, st.spp};
        nvirt    = virt;
        swap     = 1'b0;
        if (host_path) begin
            nst.spv = 1'b0;
            nvirt   = st.spv;
            swap    = st.spv;
        end
    end
endmodule

// File: rtl/trap_ret_mret.sv
module trap_ret_mret
    import trap_ret_pkg::*;
(
    input  stat_t       st,
    input  logic        virt,
    input  logic        has_h,
    output stat_t       nst,
    output logic [1:0]  npriv,
    output logic        nvirt,
    output logic        swap
);
    always_comb begin
        nst      = st;
        nst.mie  = st.mpie;
        nst.mpie = 1'b1;
        nst.mpp  = PRIV_U;
        nst.mpv  = 1'b0;
        npriv    = st.mpp;
        nvirt    = virt;
        swap     = 1'b0;
        if (has_h) begin
            nvirt = st.mpv;
            swap  = st.mpv;
        end
    end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trap_ret_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RULE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_valid,
    input  logic              ret_is_m,
    input  logic [1:0]        priv_in,
    input  logic              virt_in,
    input  logic              has_c,
    input  logic              has_h,
    input  logic              has_pmp,
    input  logic [RULE_W-1:0] pmp_rules,
    input  logic [XLEN-1:0]   sepc,
    input  logic [XLEN-1:0]   mepc,
    input  logic              sie_in,
    input  logic              spie_in,
    input  logic              spp_in,
    input  logic              mie_in,
    input  logic              mpie_in,
    input  logic [1:0]        mpp_in,
    input  logic              mpv_in,
    input  logic              spv_in,
    input  logic              tsr_in,
    input  logic              vtsr_in,
    output logic              done,
    output logic              exc_valid,
    output logic [4:0]        exc_cause,
    output logic [XLEN-1:0]   pc_out,
    output logic [1:0]        priv_out,
    output logic              virt_out,
    output logic              sie_out,
    output logic              spie_out,
    output logic              spp_out,
    output logic              mie_out,
    output logic              mpie_out,
    output logic [1:0]        mpp_out,
    output logic              mpv_out,
    output logic              spv_out,
    output logic              swap_req
);
    stat_t           st_in, st_s, st_m, st_q;
    logic [1:0]      priv_s, priv_m;
    logic            virt_s, virt_m, swap_s, swap_m;
    logic [XLEN-1:0] ret_pc;
    logic            fault;
    cause_e          cause;

    assign st_in  = '{sie: sie_in, spie: spie_in, spp: spp_in, mie: mie_in,
                      mpie: mpie_in, mpp: mpp_in, mpv: mpv_in, spv: spv_in};
    assign ret_pc = ret_is_m ? mepc : sepc;

    trap_ret_check #(.RULE_W(RULE_W)) u_check (
        .is_m(ret_is_m), .priv(priv_in), .virt(virt_in), .tsr(tsr_in),
        .vtsr(vtsr_in), .mpp(mpp_in), .has_c(has_c), .has_h(has_h),
        .has_pmp(has_pmp), .rules(pmp_rules), .pc_low(ret_pc[1:0]),
        .fault(fault), .cause(cause)
    );

    trap_ret_sret u_sret (
        .st(st_in), .virt(virt_in), .has_h(has_h),
        .nst(st_s), .npriv(priv_s), .nvirt(virt_s), .swap(swap_s)
    );

    trap_ret_mret u_mret (
        .st(st_in), .virt(virt_in), .has_h(has_h),
        .nst(st_m), .npriv(priv_m), .nvirt(virt_m), .swap(swap_m)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            exc_valid <= 1'b0;
            exc_cause <= 5'd0;
            swap_req  <= 1'b0;
            pc_out    <= '0;
            priv_out  <= PRIV_M;
            virt_out  <= 1'b0;
            st_q      <= '0;
        end else begin
            done      <= ret_valid && !fault;
            exc_valid <= ret_valid && fault;
            swap_req  <= 1'b0;
            if (ret_valid && fault) begin
                exc_cause <= cause;
            end
            if (ret_valid && !fault) begin
                pc_out   <= ret_pc;
                priv_out <= ret_is_m ? priv_m : priv_s;
                virt_out <= ret_is_m ? virt_m : virt_s;
                st_q     <= ret_is_m ? st_m : st_s;
                swap_req <= ret_is_m ? swap_m : swap_s;
            end
        end
    end

    assign sie_out  = st_q.sie;
    assign spie_out = st_q.spie;
    assign spp_out  = st_q.spp;
    assign mie_out  = st_q.mie;
    assign mpie_out = st_q.mpie;
    assign mpp_out  = st_q.mpp;
    assign mpv_out  = st_q.mpv;
    assign spv_out  = st_q.spv;

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(exc_valid && done));

    a_r5_hold_on_fault: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ($stable(pc_out) && $stable(priv_out) &&
                       $stable(virt_out) && $stable(st_q) && !swap_req));

    a_r8_mret_clears: assert property (@(posedge clk) disable iff (rst)
        (done && $past(ret_is_m)) |-> (mpp_out == PRIV_U && !mpv_out && mpie_out));

    a_r7_sret_spie: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(ret_is_m)) |-> (spie_out && !spp_out));

    a_r11_swap_with_done: assert property (@(posedge clk) disable iff (rst)
        swap_req |-> done);

    a_r11_strobe_origin: assert property (@(posedge clk) disable iff (rst)
        (done || exc_valid) |-> $past(ret_valid));

endmodule

// File: tb/trap_return_unit_tb.sv
module trap_return_unit_tb;
    localparam int XLEN   = 32;
    localparam int RULE_W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic              rst, ret_valid, ret_is_m, virt_in, has_c, has_h, has_pmp;
    logic [1:0]        priv_in, mpp_in;
    logic [RULE_W-1:0] pmp_rules;
    logic [XLEN-1:0]   sepc, mepc;
    logic              sie_in, spie_in, spp_in, mie_in, mpie_in, mpv_in, spv_in, tsr_in, vtsr_in;
    logic              done, exc_valid, virt_out, sie_out, spie_out, spp_out;
    logic              mie_out, mpie_out, mpv_out, spv_out, swap_req;
    logic [4:0]        exc_cause;
    logic [XLEN-1:0]   pc_out;
    logic [1:0]        priv_out, mpp_out;

    trap_return_unit #(.XLEN(XLEN), .RULE_W(RULE_W)) u_dut (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_is_m(ret_is_m),
        .priv_in(priv_in), .virt_in(virt_in), .has_c(has_c), .has_h(has_h),
        .has_pmp(has_pmp), .pmp_rules(pmp_rules), .sepc(sepc), .mepc(mepc),
        .sie_in(sie_in), .spie_in(spie_in), .spp_in(spp_in), .mie_in(mie_in),
        .mpie_in(mpie_in), .mpp_in(mpp_in), .mpv_in(mpv_in), .spv_in(spv_in),
        .tsr_in(tsr_in), .vtsr_in(vtsr_in), .done(done), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .pc_out(pc_out), .priv_out(priv_out),
        .virt_out(virt_out), .sie_out(sie_out), .spie_out(spie_out),
        .spp_out(spp_out), .mie_out(mie_out), .mpie_out(mpie_out),
        .mpp_out(mpp_out), .mpv_out(mpv_out), .spv_out(spv_out),
        .swap_req(swap_req)
    );

    // expected state
    logic [1:0]      e_priv = 2'd3, e_mpp = 2'd0;
    logic            e_virt = 0, e_sie = 0, e_spie = 0, e_spp = 0, e_mie = 0;
    logic            e_mpie = 0, e_mpv = 0, e_spv = 0, e_swap = 0, e_done = 0, e_exc = 0;
    logic [4:0]      e_cause = 0;
    logic [XLEN-1:0] e_pc = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model();
        logic f;
        logic [4:0] c;
        logic [XLEN-1:0] pc;
        logic mis;
        f = 0; c = 5'd2;
        pc = ret_is_m ? mepc : sepc;
        mis = !has_c && (pc[1:0] != 2'b00);
        if (!ret_is_m) begin
            if (priv_in == 2'd0) f = 1;
            else if (mis) begin f = 1; c = 5'd0; end
            else if (tsr_in && priv_in != 2'd3) f = 1;
            else if (has_h && virt_in && vtsr_in) begin f = 1; c = 5'd22; end
        end else begin
            if (priv_in != 2'd3) f = 1;
            else if (mis) begin f = 1; c = 5'd0; end
            else if (has_pmp && pmp_rules == 0 && mpp_in != 2'd3) f = 1;
        end
        e_swap = 0;
        if (f) begin
            e_exc = 1; e_done = 0; e_cause = c;
        end else begin
            e_exc = 0; e_done = 1; e_pc = pc;
            e_sie = sie_in; e_spie = spie_in; e_spp = spp_in; e_mie = mie_in;
            e_mpie = mpie_in; e_mpp = mpp_in; e_mpv = mpv_in; e_spv = spv_in;
            e_virt = virt_in;
            if (!ret_is_m) begin
                e_priv = {1'b0, spp_in}; e_sie = spie_in; e_spie = 1; e_spp = 0;
                if (has_h && !virt_in) begin
                    e_spv = 0; e_virt = spv_in; e_swap = spv_in;
                end
            end else begin
                e_priv = mpp_in; e_mie = mpie_in; e_mpie = 1; e_mpp = 0; e_mpv = 0;
                if (has_h) begin e_virt = mpv_in; e_swap = mpv_in; end
            end
        end
    endtask

    task automatic check_state(input string req);
        check(req, "state",
              {52'd0, priv_out, virt_out, sie_out, spie_out, spp_out, mie_out,
               mpie_out, mpp_out, mpv_out, spv_out},
              {52'd0, e_priv, e_virt, e_sie, e_spie, e_spp, e_mie,
               e_mpie, e_mpp, e_mpv, e_spv});
        check(req, "pc", {32'd0, pc_out}, {32'd0, e_pc});
    endtask

    task automatic run(input string req);
        @(negedge clk);
        ret_valid = 1'b1;
        model();
        @(negedge clk);
        ret_valid = 1'b0;
        check(req, "done/exc/swap", {61'd0, done, exc_valid, swap_req},
              {61'd0, e_done, e_exc, e_swap});
        if (e_exc) check(req, "cause", {59'd0, exc_cause}, {59'd0, e_cause});
        check_state(req);
        @(negedge clk);
        check("R11", "pulse end", {61'd0, done, exc_valid, swap_req}, 64'd0);
    endtask

    task automatic defaults();
        ret_is_m = 0; priv_in = 3; virt_in = 0; has_c = 1; has_h = 1; has_pmp = 0;
        pmp_rules = 0; sepc = 32'h100; mepc = 32'h200;
        sie_in = 0; spie_in = 0; spp_in = 0; mie_in = 0; mpie_in = 0; mpp_in = 0;
        mpv_in = 0; spv_in = 0; tsr_in = 0; vtsr_in = 0;
    endtask

    function automatic logic [1:0] rand_priv();
        logic [1:0] p;
        p = 2'($urandom_range(0, 2));
        return (p == 2'd2) ? 2'd3 : p;
    endfunction

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1; ret_valid = 0;
        defaults();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R11", "reset pulses", {61'd0, done, exc_valid, swap_req}, 64'd0);
        check_state("R11");

        // R1 privilege checks
        defaults(); priv_in = 0; run("R1");
        defaults(); ret_is_m = 1; priv_in = 1; run("R1");
        // R5: privilege wins over misalignment
        defaults(); priv_in = 0; has_c = 0; sepc = 32'h101; run("R5");
        // R2 alignment
        defaults(); ret_is_m = 1; has_c = 0; mepc = 32'h202; run("R2");
        defaults(); ret_is_m = 1; has_c = 1; mepc = 32'h202; mpie_in = 1; run("R2");
        // R3 trap bit
        defaults(); priv_in = 1; tsr_in = 1; run("R3");
        defaults(); priv_in = 3; tsr_in = 1; spp_in = 1; spie_in = 1; run("R3");
        // R4 virtual trap and R5 ordering
        defaults(); priv_in = 1; virt_in = 1; vtsr_in = 1; run("R4");
        defaults(); priv_in = 1; virt_in = 1; vtsr_in = 1; tsr_in = 1; run("R5");
        defaults(); priv_in = 1; virt_in = 1; vtsr_in = 1; has_h = 0; run("R4");
        // R6 host-side supervisor return
        defaults(); spv_in = 1; spp_in = 1; spie_in = 0; sie_in = 1; run("R6");
        defaults(); spv_in = 0; spp_in = 0; spie_in = 1; run("R6");
        // R7 other supervisor return
        defaults(); priv_in = 1; virt_in = 1; spv_in = 1; spp_in = 1; run("R7");
        defaults(); has_h = 0; spv_in = 1; spp_in = 1; run("R7");
        // R8 / R9 machine return
        defaults(); ret_is_m = 1; mpp_in = 1; mpv_in = 1; mpie_in = 1; sie_in = 1; run("R9");
        defaults(); ret_is_m = 1; has_h = 0; mpp_in = 0; mpv_in = 1; virt_in = 1; run("R9");
        defaults(); ret_is_m = 1; mpp_in = 3; mie_in = 1; mpie_in = 0; run("R8");
        // R10 protection with no rules
        defaults(); ret_is_m = 1; has_pmp = 1; pmp_rules = 0; mpp_in = 0; run("R10");
        defaults(); ret_is_m = 1; has_pmp = 1; pmp_rules = 0; mpp_in = 3; run("R10");
        defaults(); ret_is_m = 1; has_pmp = 1; pmp_rules = 2; mpp_in = 1; run("R10");
        // R5 ordering on machine return: misaligned beats rule check
        defaults(); ret_is_m = 1; has_pmp = 1; has_c = 0; mepc = 32'h203; run("R5");

        // random mix
        for (int i = 0; i < 400; i++) begin
            ret_is_m = 1'($urandom); priv_in = rand_priv(); virt_in = 1'($urandom);
            has_c = 1'($urandom); has_h = 1'($urandom); has_pmp = 1'($urandom);
            pmp_rules = RULE_W'($urandom_range(0, 2));
            sepc = $urandom; mepc = $urandom;
            sie_in = 1'($urandom); spie_in = 1'($urandom); spp_in = 1'($urandom);
            mie_in = 1'($urandom); mpie_in = 1'($urandom); mpp_in = rand_priv();
            mpv_in = 1'($urandom); spv_in = 1'($urandom);
            tsr_in = 1'($urandom); vtsr_in = 1'($urandom);
            run(ret_is_m ? "R8" : "R7");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule